// File: doc/BRIEF.md
# Prioritised Interrupt Identification Unit

This block gathers every interrupt cause of a message-oriented serial bus controller onto a single request line and tells software which cause to service first. Three classes of cause feed it: status events (a frame sent, a frame received, an error code recorded), error-level changes (the warning level and the bus-off condition moving either way), and a pending flag per message object. It holds the status register and presents the identification code, and it drives the request line seen by the processor.

Software reads the identification code. A code of 1 means the status register must be read. That read also withdraws the status-class request. Codes from 2 upward name a message object whose own pending flag must be cleared elsewhere. A code of 0 means that everything has been serviced. A single completed transmission can raise both a status request and an object request. The status request wins first, and the object request then surfaces by itself once the status register has been read.

Top module: `iid_unit`

## Requirements
- R1: After reset the status register reads 0x00, the identification code is 0 and the request line is low.
- R2: The identification code is 0 when nothing is pending and 1 when the status-class request is pending. Object pending input bit k (k = 0..14, object k+1) gives code k+2, so codes 2..16 stand for objects 1..15.
- R3: Code 1 ranks above every object. Among the objects, the lowest-numbered pending one is reported.
- R4: Status register layout: last-error code in bits [2:0], transmit-done in bit 3, receive-done in bit 4, warning level in bit 6, bus-off in bit 7, bit 5 always 0. A transmit or receive event sets its bit on the next clock. An error event stores its 3-bit code on the next clock.
- R5: Control register layout: bit 1 is global enable, bit 2 is status enable, bit 3 is error enable. When status enable is 1, a transmit event, a receive event or an error event with a nonzero code makes the status-class request pending on the next clock. A zero code never raises the request. When status enable is 0, none of these events raises the request.
- R6: The warning-level and bus-off bits follow their inputs one clock later. When error enable is 1, any change of either input, rising or falling, makes the status-class request pending. When error enable is 0, such a change raises no request.
- R7: A status register read strobe clears the status-class request on the next clock. If a new enabled event arrives in the same cycle as the read, the request stays pending.
- R8: A status write loads bits [4:0] from the write data. Bits 5, 6 and 7 ignore the write. A transmit, receive or error event in the same cycle overrides the written value of its own field.
- R9: The request line is high exactly when the global enable is 1 and the identification code is nonzero.
- R10: When a transmit event and an object pending flag arrive together, the code reads 1 first. After the status read it reads that object's code, while the object flag is held.
- R11: The identification code follows the object pending inputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_reg | input | 8 | Control register value (bit1 global, bit2 status, bit3 error enable) |
| ev_txok | input | 1 | One-cycle pulse: frame transmitted |
| ev_rxok | input | 1 | One-cycle pulse: frame received |
| ev_err | input | 1 | One-cycle pulse: an error code is recorded |
| ev_err_code | input | 3 | Code stored with ev_err |
| ewrn_in | input | 1 | Warning-level condition |
| boff_in | input | 1 | Bus-off condition |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data |
| obj_pend | input | 15 | Per-object pending flags, bit k is object k+1 |
| stat_rdata | output | 8 | Status register contents |
| int_id | output | 8 | Identification code |
| irq | output | 1 | Global interrupt request |

## Verification
Two pairs of functions can meet in one clock. A status read can coincide with a fresh enabled event, and a software write can land in the same cycle as a hardware event on the field it writes. The bench forces both meetings on purpose. It expects the request to survive the read, and it expects the hardware value to win over the written one. A transmit event that arrives together with an object flag shows the code passing from 1 to the object's code across the read. Every output is compared against a behavioural model on every clock.

// File: rtl/iid_pkg.sv
package iid_pkg;
  localparam int REG_W    = 8;
  localparam int CODE_W   = 3;
  localparam int CTL_IE   = 1;
  localparam int CTL_SIE  = 2;
  localparam int CTL_EIE  = 3;

  typedef struct packed {
    logic              boff;
    logic              ewrn;
    logic              rsvd;
    logic              rxok;
    logic              txok;
    logic [CODE_W-1:0] lec;
  } stat_t;

  localparam stat_t STAT_RST = '0;
endpackage

// File: rtl/iid_status_regs.sv
module iid_status_regs
  import iid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_txok,
  input  logic              ev_rxok,
  input  logic              ev_err,
  input  logic [CODE_W-1:0] ev_err_code,
  input  logic              ewrn_in,
  input  logic              boff_in,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output stat_t             stat_q,
  output logic              stat_evt,
  output logic              err_evt
);
  stat_t stat_d;
  logic  upd_en;

  always_comb begin
    stat_d      = stat_q;
    stat_d.rsvd = 1'b0;
    if (wr_en) begin
      stat_d.lec  = wr_data[CODE_W-1:0];
      stat_d.txok = wr_data[3];
      stat_d.rxok = wr_data[4];
    end
    if (ev_txok) stat_d.txok = 1'b1;
    if (ev_rxok) stat_d.rxok = 1'b1;
    if (ev_err)  stat_d.lec  = ev_err_code;
    stat_d.ewrn = ewrn_in;
    stat_d.boff = boff_in;
  end

  assign upd_en   = wr_en | ev_txok | ev_rxok | ev_err |
                    (ewrn_in ^ stat_q.ewrn) | (boff_in ^ stat_q.boff);
  assign stat_evt = ev_txok | ev_rxok | (ev_err & (ev_err_code != '0));
  assign err_evt  = (ewrn_in ^ stat_q.ewrn) | (boff_in ^ stat_q.boff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= STAT_RST;
    else if (upd_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/iid_pend_ctl.sv
module iid_pend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sie,
  input  logic eie,
  input  logic stat_evt,
  input  logic err_evt,
  input  logic rd_clr,
  output logic pend_q
);
  logic set_req;
  logic pend_d;

  always_comb begin
    set_req = (sie & stat_evt) | (eie & err_evt);
    pend_d  = set_req | (pend_q & ~rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/iid_prio_enc.sv
module iid_prio_enc #(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 8
) (
  input  logic               stat_pend,
  input  logic [NUM_OBJ-1:0] obj,
  output logic [ID_W-1:0]    id
);
  localparam int FIRST_OBJ_CODE = 2;

  logic [NUM_OBJ:0]   above;
  logic [NUM_OBJ-1:0] first;
  logic [ID_W-1:0]    term [NUM_OBJ];
  logic [ID_W-1:0]    obj_id;

  assign above[0] = 1'b0;

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_stage
    assign first[i]    = obj[i] & ~above[i];
    assign above[i+1]  = above[i] | obj[i];
    assign term[i]     = first[i] ? ID_W'(i + FIRST_OBJ_CODE) : '0;
  end

  always_comb begin
    obj_id = '0;
    for (int i = 0; i < NUM_OBJ; i++) obj_id = obj_id | term[i];
  end

  assign id = stat_pend ? ID_W'(1) : obj_id;
endmodule

// File: rtl/iid_unit.sv
module iid_unit
  import iid_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         ctl_reg,
  input  logic               ev_txok,
  input  logic               ev_rxok,
  input  logic               ev_err,
  input  logic [2:0]         ev_err_code,
  input  logic               ewrn_in,
  input  logic               boff_in,
  input  logic               stat_rd,
  input  logic               stat_wr,
  input  logic [7:0]         stat_wdata,
  input  logic [NUM_OBJ-1:0] obj_pend,
  output logic [7:0]         stat_rdata,
  output logic [7:0]         int_id,
  output logic               irq
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  stat_t      stat_q;
  logic       stat_evt;
  logic       err_evt;
  logic       pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  iid_status_regs u_stat (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .ev_txok    (ev_txok),
    .ev_rxok    (ev_rxok),
    .ev_err     (ev_err),
    .ev_err_code(ev_err_code),
    .ewrn_in    (ewrn_in),
    .boff_in    (boff_in),
    .wr_en      (stat_wr),
    .wr_data    (stat_wdata),
    .stat_q     (stat_q),
    .stat_evt   (stat_evt),
    .err_evt    (err_evt)
  );

  iid_pend_ctl u_pend (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .sie     (ctl_reg[CTL_SIE]),
    .eie     (ctl_reg[CTL_EIE]),
    .stat_evt(stat_evt),
    .err_evt (err_evt),
    .rd_clr  (stat_rd),
    .pend_q  (pend_q)
  );

  iid_prio_enc #(.NUM_OBJ(NUM_OBJ), .ID_W(8)) u_enc (
    .stat_pend(pend_q),
    .obj      (obj_pend),
    .id       (int_id)
  );

  assign stat_rdata = stat_q;
  assign irq        = ctl_reg[CTL_IE] & (int_id != 8'd0);
endmodule

// File: rtl/iid_unit_chk.sv
module iid_unit_chk #(
  parameter int NUM_OBJ = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         ctl_reg,
  input logic               ev_txok,
  input logic               ev_rxok,
  input logic               ev_err,
  input logic [2:0]         ev_err_code,
  input logic               ewrn_in,
  input logic               boff_in,
  input logic               stat_rd,
  input logic [NUM_OBJ-1:0] obj_pend,
  input logic [7:0]         stat_rdata,
  input logic [7:0]         int_id,
  input logic               irq
);
  p_zero_means_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id == 8'd0) |-> (obj_pend == '0));

  p_lowest_object_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id >= 8'd2) |-> (obj_pend[int_id - 8'd2] &&
      $countones(obj_pend & ((NUM_OBJ'(1) << (int_id - 8'd2)) - NUM_OBJ'(1))) == 0));

  p_txok_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txok |=> stat_rdata[3]);

  p_rx_event_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reg[2] && ev_rxok) |=> (int_id == 8'd1));

  p_level_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reg[3] && (ewrn_in != stat_rdata[6])) |=> (int_id == 8'd1));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_txok && !ev_rxok && !ev_err &&
     ewrn_in == stat_rdata[6] && boff_in == stat_rdata[7]) |=> (int_id != 8'd1));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[5]);

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_reg[1] |-> !irq);
endmodule

bind iid_unit iid_unit_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .ctl_reg    (ctl_reg),
  .ev_txok    (ev_txok),
  .ev_rxok    (ev_rxok),
  .ev_err     (ev_err),
  .ev_err_code(ev_err_code),
  .ewrn_in    (ewrn_in),
  .boff_in    (boff_in),
  .stat_rd    (stat_rd),
  .obj_pend   (obj_pend),
  .stat_rdata (stat_rdata),
  .int_id     (int_id),
  .irq        (irq)
);

// File: tb/sim_iid_unit.sv
`timescale 1ns/1ps
module sim_iid_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ctl_reg;
  logic        ev_txok, ev_rxok, ev_err;
  logic [2:0]  ev_err_code;
  logic        ewrn_in, boff_in;
  logic        stat_rd, stat_wr;
  logic [7:0]  stat_wdata;
  logic [14:0] obj_pend;
  logic [7:0]  stat_rdata, int_id;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference model state
  bit       m_tx, m_rx, m_ew, m_bo, m_pend;
  bit [2:0] m_lec;

  always #10 clk = ~clk;

  iid_unit u0 (.*);

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic int exp_id();
    if (m_pend) return 1;
    for (int k = 0; k < 15; k++) if (obj_pend[k]) return k + 2;
    return 0;
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_bo, m_ew, 1'b0, m_rx, m_tx, m_lec};
  endfunction

  task automatic compare();
    int       eid  = exp_id();
    bit [7:0] est  = exp_stat();
    bit       eirq = ctl_reg[1] && eid != 0;
    checks++;
    if (stat_rdata !== est || int_id !== 8'(eid) || irq !== eirq) begin
      fails++;
      $display("FAIL %s: stat=%02h id=%0d irq=%0b expected stat=%02h id=%0d irq=%0b",
               tag, stat_rdata, int_id, irq, est, eid, eirq);
    end
  endtask

  // advance one clock: model commit, then compare at the falling edge
  task automatic tick();
    bit       n_tx = m_tx, n_rx = m_rx;
    bit [2:0] n_lec = m_lec;
    bit       sev, eev, n_pend;
    if (stat_wr) begin n_lec = stat_wdata[2:0]; n_tx = stat_wdata[3]; n_rx = stat_wdata[4]; end
    if (ev_txok) n_tx = 1;
    if (ev_rxok) n_rx = 1;
    if (ev_err)  n_lec = ev_err_code;
    sev = ev_txok || ev_rxok || (ev_err && ev_err_code != 0);
    eev = (ewrn_in != m_ew) || (boff_in != m_bo);
    n_pend = (ctl_reg[2] && sev) || (ctl_reg[3] && eev) || (m_pend && !stat_rd);
    @(posedge clk);
    m_tx = n_tx; m_rx = n_rx; m_lec = n_lec; m_pend = n_pend;
    m_ew = ewrn_in; m_bo = boff_in;
    @(negedge clk);
    compare();
    ev_txok = 0; ev_rxok = 0; ev_err = 0; ev_err_code = 0;
    stat_rd = 0; stat_wr = 0; stat_wdata = 0;
  endtask

  task automatic settle();
    #1; compare();
  endtask

  initial begin
    rst_n = 0; ctl_reg = 0; ev_txok = 0; ev_rxok = 0; ev_err = 0; ev_err_code = 0;
    ewrn_in = 0; boff_in = 0; stat_rd = 0; stat_wr = 0; stat_wdata = 0; obj_pend = 0;
    m_tx = 0; m_rx = 0; m_ew = 0; m_bo = 0; m_pend = 0; m_lec = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    repeat (4) tick();

    // R2 / R3 / R11: objects only, global enable on
    ctl_reg = 8'h02;
    tag = "R11"; obj_pend = 15'h0001; settle();
    tag = "R2";  obj_pend = 15'h4000; settle();
    tag = "R3";  obj_pend = 15'h4a10; settle();
    tag = "R11"; obj_pend = 15'h0000; settle();
    tick();

    // R4/R5: events with status enable off set bits but raise nothing
    tag = "R5"; ev_txok = 1; tick(); ev_err = 1; ev_err_code = 3'd5; tick(); tick();
    // R4/R5: status enable on
    ctl_reg = 8'h06;
    tag = "R5"; ev_rxok = 1; tick(); tick();
    tag = "R7"; stat_rd = 1; tick(); tick();
    tag = "R5"; ev_err = 1; ev_err_code = 3'd0; tick(); tick();
    tag = "R4"; ev_err = 1; ev_err_code = 3'd6; tick();
    tag = "R7"; stat_rd = 1; tick();

    // R6: level changes
    tag = "R6"; ewrn_in = 1; tick(); tick();
    ctl_reg = 8'h0a;
    boff_in = 1; tick(); stat_rd = 1; tick();
    ewrn_in = 0; tick(); stat_rd = 1; tick();
    boff_in = 0; tick(); stat_rd = 1; tick();

    // R7: read and new event in the same cycle
    ctl_reg = 8'h0e;
    tag = "R7"; ev_txok = 1; tick(); stat_rd = 1; ev_rxok = 1; tick(); tick();
    stat_rd = 1; tick();

    // R8: writes, write colliding with events
    tag = "R8"; stat_wr = 1; stat_wdata = 8'hE0; tick();
    stat_wr = 1; stat_wdata = 8'h1B; tick();
    stat_wr = 1; stat_wdata = 8'h00; ev_txok = 1; tick();
    stat_wr = 1; stat_wdata = 8'h07; ev_err = 1; ev_err_code = 3'd2; tick();
    stat_rd = 1; tick();

    // R9: global enable off masks the line
    tag = "R9"; ctl_reg = 8'h0c; obj_pend = 15'h0100; settle(); ev_txok = 1; tick();
    ctl_reg = 8'h0e; settle(); stat_rd = 1; obj_pend = 0; tick();

    // R10: transmit event with object flag together
    tag = "R10"; ev_txok = 1; obj_pend = 15'h0004; tick(); tick();
    stat_rd = 1; tick(); tick();
    obj_pend = 0; settle(); tick();

    // mixed traffic
    tag = "R3";
    for (int n = 0; n < 300; n++) begin
      ctl_reg     = 8'($urandom) & 8'h0e;
      ev_txok     = ($urandom % 7) == 0;
      ev_rxok     = ($urandom % 7) == 0;
      ev_err      = ($urandom % 5) == 0;
      ev_err_code = 3'($urandom);
      if (($urandom % 11) == 0) ewrn_in = ~ewrn_in;
      if (($urandom % 13) == 0) boff_in = ~boff_in;
      stat_rd     = ($urandom % 4) == 0;
      stat_wr     = ($urandom % 9) == 0;
      stat_wdata  = 8'($urandom);
      obj_pend    = 15'($urandom) & 15'($urandom) & 15'($urandom);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule